// File: doc/BRIEF.md
# Interrupt flag and enable controller

This block collects interrupt events from seven peripheral sources (two timers, a shift register and control-line edge detectors) into a flag register. It pairs that register with an enable register and drives one interrupt request line toward a processor. Software reaches both registers through a byte-wide register port. A select input picks the flag register or the enable register. A write strobe applies the write data to the selected register, and the read data always shows the selected register.

The enable register is never written as a plain value. Bit 7 of the write data chooses whether the ones in bits 6:0 turn enables on or turn them off. Flags are cleared by writing ones to them, and a peripheral can also clear its own flag with a strobe. A new event always wins over a clear that lands in the same cycle, so no event is lost. The request output is a register, so it follows the flag and enable state one cycle late.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset every flag and every enable is 0. The request output is 0, a flag read returns 0x00 and an enable read returns 0x80.
- R2: A 1 on bit i of the source-set input sets flag i at the next clock edge. Bit 6 is timer 1, bit 5 is timer 2 and bit 2 is the shift register.
- R3: A write with the select at 0 (flag register) clears each flag whose bit 6:0 in the write data is 1. Flags written as 0 keep their value.
- R4: A 1 on bit i of the source-clear input clears flag i at the next clock edge.
- R5: A write with the select at 1 (enable register) and data bit 7 at 1 ORs data bits 6:0 into the enables.
- R6: A write with the select at 1 and data bit 7 at 0 clears each enable whose data bit is 1. The other enables keep their value.
- R7: With the select at 1, the read data is the enables in bits 6:0 with bit 7 at 1.
- R8: With the select at 0, the read data is the flags in bits 6:0. Bit 7 is 1 exactly when some flag is set and its enable is set.
- R9: The request output is registered. After each clock edge it equals the OR of (flags AND enables) as they stood before that edge.
- R10: When a source sets a flag in the same cycle as a register write or a source-clear strobe that clears it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_sel | input | 1 | Register select: 0 flag register, 1 enable register |
| cpu_wr | input | 1 | Write strobe for the selected register |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data of the selected register |
| src_set | input | 7 | Per-source event pulses that set flags |
| src_clr | input | 7 | Per-source clear strobes |
| irq | output | 1 | Registered interrupt request |

## Verification
A source event can fall in the same cycle as a clear of the same flag, whether that clear comes from a write-one-to-clear or from a peripheral strobe. The bench provokes both collisions on purpose. It then adds a long stretch of random traffic in which set, strobe-clear and register writes coincide freely. A behavioural model with set-over-clear priority predicts the flags, enables, read data and the one-cycle-late request, and it is compared with the design after every clock.

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int NSRC = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_sel,
  input  logic            cpu_wr,
  input  logic [NSRC:0]   cpu_wdata,
  output logic [NSRC:0]   cpu_rdata,
  input  logic [NSRC-1:0] src_set,
  input  logic [NSRC-1:0] src_clr,
  output logic            irq
);
  localparam int MODE_BIT = NSRC;

  logic [NSRC-1:0] flag_q, en_q;
  logic [NSRC-1:0] flag_wclr, en_next;
  logic            pending;

  assign flag_wclr = (cpu_wr && !cpu_sel) ? cpu_wdata[NSRC-1:0] : '0;
  assign pending   = |(flag_q & en_q);

  always_comb begin
    en_next = en_q;
    if (cpu_wr && cpu_sel) begin
      if (cpu_wdata[MODE_BIT]) en_next = en_q | cpu_wdata[NSRC-1:0];
      else                     en_next = en_q & ~cpu_wdata[NSRC-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      irq    <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~flag_wclr & ~src_clr) | src_set;
      en_q   <= en_next;
      irq    <= pending;
    end
  end

  assign cpu_rdata = cpu_sel ? {1'b1, en_q} : {pending, flag_q};
endmodule

module irq_flag_ctrl_chk #(
  parameter int NSRC = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_sel,
  input logic            cpu_wr,
  input logic [NSRC:0]   cpu_wdata,
  input logic [NSRC:0]   cpu_rdata,
  input logic [NSRC-1:0] src_set,
  input logic [NSRC-1:0] src_clr,
  input logic            irq,
  input logic [NSRC-1:0] flag_q,
  input logic [NSRC-1:0] en_q
);
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (src_set != '0) |=> ((flag_q & $past(src_set)) == $past(src_set)));

  p_flag_wclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !cpu_sel && src_set == '0) |=> ((flag_q & $past(cpu_wdata[NSRC-1:0])) == '0));

  p_strobe_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_set == '0 && src_clr != '0) |=> ((flag_q & $past(src_clr)) == '0));

  p_en_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_sel && cpu_wdata[NSRC])
      |=> ((en_q & $past(cpu_wdata[NSRC-1:0])) == $past(cpu_wdata[NSRC-1:0])));

  p_en_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_sel && !cpu_wdata[NSRC]) |=> ((en_q & $past(cpu_wdata[NSRC-1:0])) == '0));

  p_en_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_sel |-> (cpu_rdata[NSRC] && cpu_rdata[NSRC-1:0] == en_q));

  p_irq_late_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(flag_q & en_q))));

  p_flag_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_set == '0 && src_clr == '0 && !(cpu_wr && !cpu_sel)) |=> $stable(flag_q));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
  .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .src_set(src_set),
  .src_clr(src_clr), .irq(irq), .flag_q(flag_q), .en_q(en_q)
);

// File: tb/irq_flag_ctrl_test.sv
module irq_flag_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_sel = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic [6:0] src_set = 7'h00;
  logic [6:0] src_clr = 7'h00;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int m_flag = 0;
  int m_en = 0;
  int m_irq = 0;

  always #5 clk = ~clk;

  irq_flag_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .src_set(src_set),
    .src_clr(src_clr), .irq(irq)
  );

  task automatic check(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, actual, expected);
    end
  endtask

  function automatic int model_read(bit sel);
    if (sel) return 'h80 | m_en;
    return (((m_flag & m_en) != 0) ? 'h80 : 0) | m_flag;
  endfunction

  task automatic step(string tag, bit sel, bit wr, int wdata, int set, int clr);
    cpu_sel = sel; cpu_wr = wr; cpu_wdata = wdata[7:0];
    src_set = set[6:0]; src_clr = clr[6:0];
    #1;
    check({tag, sel ? "/R7" : "/R8"}, int'(cpu_rdata), model_read(sel));
    check({tag, "/R9"}, int'(irq), m_irq);
    @(posedge clk);
    m_irq = ((m_flag & m_en) != 0) ? 1 : 0;
    if (wr && !sel) m_flag = m_flag & ~(wdata & 'h7f);
    m_flag = (m_flag & ~clr) | set;
    if (wr && sel) begin
      if ((wdata & 'h80) != 0) m_en = m_en | (wdata & 'h7f);
      else                     m_en = m_en & ~(wdata & 'h7f);
    end
    @(negedge clk);
    cpu_wr = 1'b0; src_set = '0; src_clr = '0;
  endtask

  task automatic peek(string tag, bit sel, int expected);
    cpu_sel = sel; cpu_wr = 1'b0; src_set = '0; src_clr = '0;
    #1;
    check(tag, int'(cpu_rdata), expected);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    peek("R1 flag read in reset", 0, 'h00);
    peek("R1 enable read in reset", 1, 'h80);
    check("R1 irq in reset", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    step("R2", 0, 0, 0, 'h64, 0);
    peek("R2 timer1/timer2/shift flags", 0, 'h64);
    step("R5", 1, 1, 'hC0, 0, 0);
    peek("R8 summary after enable", 0, 'hE4);
    step("R9", 0, 0, 0, 0, 0);
    check("R9 irq one cycle late", int'(irq), 1);
    step("R5", 1, 1, 'h84, 0, 0);
    peek("R7 enable read", 1, 'hC4);
    step("R6", 1, 1, 'h40, 0, 0);
    peek("R6 enable cleared", 1, 'h84);
    step("R3", 0, 1, 'h04, 0, 0);
    peek("R3 flag cleared", 0, 'h60);
    step("R9", 0, 0, 0, 0, 0);
    check("R9 irq dropped", int'(irq), 0);
    step("R4", 0, 0, 0, 0, 'h20);
    peek("R4 strobe clear", 0, 'h40);
    step("R10", 0, 1, 'h04, 'h04, 0);
    peek("R10 set beats write clear", 0, 'hC4);
    step("R10", 0, 0, 0, 'h40, 'h40);
    peek("R10 set beats strobe clear", 0, 'hC4);
    step("R3", 0, 1, 'h7F, 0, 0);
    peek("R3 all cleared", 0, 'h00);

    for (int i = 0; i < 400; i++) begin
      step("R10 random", ($urandom % 2) == 1, ($urandom % 3) == 0,
           int'($urandom % 256), int'($urandom % 128) & int'($urandom % 128),
           int'($urandom % 128));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule